// File: doc/BRIEF.md
# Reset-Gated I2C Byte Memory Target

This block is the bus-facing front end of a small I2C memory. A fast system clock oversamples the SCL and SDA lines and filters them. The block finds START and STOP conditions, shifts in the device address byte and checks it, and acknowledges the byte when it matches. It then either takes a word address and one data byte to store, or returns stored bytes to the controller starting at the current pointer. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

Two guards protect the stored data. The first is a system hold input: while it is high, any transaction in flight is dropped, the bus is released and nothing new is accepted. A programming cycle that has already begun still finishes. The second is a lock input that refuses every write. After each accepted write, a programming timer models the slow commit to nonvolatile storage. While it runs, the block does not answer its address, so a controller can poll for completion.

Top module: `i2c_mem_target`

## Requirements
- R1: After `rst`, `sda_pull` is low and the block does not acknowledge anything until a START is seen.
- R2: A START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high. Address bytes clocked without a preceding START are not acknowledged, and every transaction is closed by a STOP.
- R3: The address byte is sent most significant bit first. Its bits 7:4 must equal `DEV_ID` (default 4'b1010), bits 3:1 are don't-care, and bit 0 selects read (1) or write (0). The block pulls SDA low in the ninth clock only on a match.
- R4: A write is address byte (bit 0 = 0), word address and data byte, each acknowledged in its ninth clock. The byte is stored at the word address when the STOP that follows is seen.
- R5: A read sends the byte at the pointer MSB first. The pointer then advances by one, wrapping from 255 to 0. A controller ACK (SDA low in the ninth clock) makes the block send the next byte, and a NACK ends the transfer.
- R6: After a word address, a repeated START followed by a read address byte returns the byte at that word address.
- R7: While `sys_hold` is high, `sda_pull` is released within one clock, the transaction in flight is dropped, and address bytes are not acknowledged. Bytes that continue the dropped transaction are not acknowledged either, and its write is never performed.
- R8: No programming cycle starts while `sys_hold` is high. A cycle that has started runs its full length even if `sys_hold` rises, and the byte is kept.
- R9: For `WR_CYCLES` clocks after a programming cycle starts, the block does not acknowledge its address.
- R10: While `wr_lock` is high, the data byte of a write is not acknowledged and memory is unchanged.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` clocks is ignored, so a short low pulse on SDA while SCL is high does not form a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high block reset |
| sys_hold | input | 1 | System reset condition; blocks bus access while high |
| wr_lock | input | 1 | Write lock; refuses all writes while high |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | When high, the open-drain SDA driver pulls the line low |

## Verification
The bench builds the block with `WR_CYCLES` set to 2000 instead of the multi-millisecond default. This makes the busy window long enough that an address poll issued just after a STOP lands inside it, yet short enough that many write-then-verify sequences fit in one run. `DEV_ID`, `SYNC_STAGES` and `FILT_LEN` keep their defaults. The bus bit period of 40 clocks leaves room for the synchronizer and filter latency, while a one-clock SDA pulse stays well below the filter length. Pointer wrap is reached by writing the top and bottom locations and reading across the boundary.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_WADDR,
        BY_WDATA
    } byte_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [3:0] id);
        return b[7:4] == id;
    endfunction

    function automatic logic is_read_req(input logic [BYTE_W-1:0] b);
        return b[0];
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(FILT_LEN + 1) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    // Level follows the synchronized input only after it has differed
    // for FILT_LEN consecutive clocks.
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b1;
            run_q <= '0;
        end else if (sync_q[SYNC_STAGES-1] == level) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            level <= sync_q[SYNC_STAGES-1];
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import i2c_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean;
    logic [NLINES-1:0] prev_q;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) filt_i (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .level(clean[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '1;
        end else begin
            prev_q <= clean;
        end
    end

    logic scl_c, sda_c, scl_p, sda_p;
    assign scl_c = clean[1];
    assign sda_c = clean[0];
    assign scl_p = prev_q[1];
    assign sda_p = prev_q[0];

    always_comb begin
        ev.scl   = scl_c;
        ev.sda   = sda_c;
        ev.rise  = scl_c & ~scl_p;
        ev.fall  = ~scl_c & scl_p;
        ev.start = scl_c & scl_p & sda_p & ~sda_c;
        ev.stop  = scl_c & scl_p & ~sda_p & sda_c;
    end
endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
    parameter int WR_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic last
);
    localparam int TW = $clog2(WR_CYCLES + 1);

    logic [TW-1:0] left_q;

    // Deliberately not gated by the system hold: a started cycle completes.
    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (go && left_q == '0) begin
            left_q <= TW'(WR_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = left_q != '0;
    assign last = left_q == TW'(1);
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter int         DEPTH       = 256,
    parameter int         WR_CYCLES   = 250000,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_hold,
    input  logic wr_lock,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull
);
    localparam int AW = $clog2(DEPTH);

    bus_ev_t              ev;
    tgt_state_e           st_q;
    byte_kind_e           kind_q;
    logic [3:0]           bit_q;
    logic [BYTE_W-1:0]    rx_q;
    logic [BYTE_W-1:0]    tx_q;
    logic                 ack_q;
    logic                 rd_q;
    logic                 mack_q;
    logic                 pend_q;
    logic [AW-1:0]        ptr_q;
    logic [BYTE_W-1:0]    wd_q;
    logic [BYTE_W-1:0]    rd_data;
    logic                 busy;
    logic                 busy_last;
    logic                 mem_we;
    logic                 ack_now;

    i2c_bus_sampler #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) samp_i (
        .clk   (clk),
        .rst   (rst),
        .scl_in(scl_in),
        .sda_in(sda_in),
        .ev    (ev)
    );

    i2c_wr_timer #(
        .WR_CYCLES(WR_CYCLES)
    ) tmr_i (
        .clk (clk),
        .rst (rst),
        .go  (mem_we),
        .busy(busy),
        .last(busy_last)
    );

    i2c_mem_array #(
        .DEPTH(DEPTH),
        .DW   (BYTE_W)
    ) mem_i (
        .clk  (clk),
        .we   (mem_we),
        .waddr(ptr_q),
        .wdata(wd_q),
        .raddr(ptr_q),
        .rdata(rd_data)
    );

    // A programming cycle begins only at a STOP outside of system hold.
    assign mem_we = ev.stop && pend_q && !sys_hold && !wr_lock && !busy;

    // Acknowledge decision for the byte just received.
    always_comb begin
        unique case (kind_q)
            BY_DEV:   ack_now = dev_match(rx_q, DEV_ID) && !busy;
            BY_WADDR: ack_now = 1'b1;
            BY_WDATA: ack_now = !wr_lock;
            default:  ack_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            kind_q   <= BY_DEV;
            bit_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            ack_q    <= 1'b0;
            rd_q     <= 1'b0;
            mack_q   <= 1'b0;
            pend_q   <= 1'b0;
            ptr_q    <= '0;
            wd_q     <= '0;
            sda_pull <= 1'b0;
        end else if (sys_hold) begin
            st_q     <= ST_IDLE;
            bit_q    <= '0;
            pend_q   <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ev.stop) begin
            st_q     <= ST_IDLE;
            pend_q   <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            st_q     <= ST_RX;
            kind_q   <= BY_DEV;
            bit_q    <= '0;
            pend_q   <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            unique case (st_q)
                ST_RX: begin
                    if (ev.rise) begin
                        rx_q  <= {rx_q[BYTE_W-2:0], ev.sda};
                        bit_q <= bit_q + 1'b1;
                    end else if (ev.fall && bit_q == 4'd8) begin
                        st_q     <= ST_ACK;
                        bit_q    <= '0;
                        ack_q    <= ack_now;
                        sda_pull <= ack_now;
                        unique case (kind_q)
                            BY_DEV:   rd_q  <= is_read_req(rx_q);
                            BY_WADDR: ptr_q <= rx_q[AW-1:0];
                            BY_WDATA: begin
                                if (!wr_lock) begin
                                    wd_q   <= rx_q;
                                    pend_q <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        sda_pull <= 1'b0;
                        if (!ack_q) begin
                            st_q <= ST_SKIP;
                        end else begin
                            unique case (kind_q)
                                BY_DEV: begin
                                    if (rd_q) begin
                                        st_q     <= ST_TX;
                                        tx_q     <= rd_data;
                                        sda_pull <= ~rd_data[BYTE_W-1];
                                    end else begin
                                        st_q   <= ST_RX;
                                        kind_q <= BY_WADDR;
                                    end
                                end
                                BY_WADDR: begin
                                    st_q   <= ST_RX;
                                    kind_q <= BY_WDATA;
                                end
                                default: st_q <= ST_SKIP;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        bit_q <= bit_q + 1'b1;
                    end else if (ev.fall) begin
                        if (bit_q == 4'd8) begin
                            st_q     <= ST_MACK;
                            bit_q    <= '0;
                            sda_pull <= 1'b0;
                            ptr_q    <= ptr_q + 1'b1;
                        end else begin
                            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                            sda_pull <= ~tx_q[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        mack_q <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (mack_q) begin
                            st_q     <= ST_TX;
                            tx_q     <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                        end else begin
                            st_q <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_mem_checker.sv
module i2c_mem_checker (
    input logic clk,
    input logic rst,
    input logic sys_hold,
    input logic wr_lock,
    input logic sda_pull,
    input logic mem_we,
    input logic bus_stop,
    input logic busy,
    input logic busy_last,
    input logic st_idle
);
    assert_hold_release_R7: assert property (@(posedge clk) disable iff (rst)
        sys_hold |=> !sda_pull);

    assert_no_we_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !sys_hold);

    assert_busy_runs_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !busy_last) |=> busy);

    assert_we_sets_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> busy);

    assert_we_at_stop_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> bus_stop);

    assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !wr_lock);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> !sda_pull);
endmodule

bind i2c_mem_target i2c_mem_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .sys_hold (sys_hold),
    .wr_lock  (wr_lock),
    .sda_pull (sda_pull),
    .mem_we   (mem_we),
    .bus_stop (ev.stop),
    .busy     (busy),
    .busy_last(busy_last),
    .st_idle  (st_q == i2c_mem_pkg::ST_IDLE)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb_top;
    localparam int WR = 2000;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst, sys_hold, wr_lock, scl_m, sda_m;
    logic sda_pull;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_mem_target #(.WR_CYCLES(WR)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .sys_hold(sys_hold),
        .wr_lock (wr_lock),
        .scl_in  (scl_m),
        .sda_in  (sda_line),
        .sda_pull(sda_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
        s = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic write_mem(input logic [7:0] a, input logic [7:0] d,
                             output logic a1, output logic a2, output logic a3);
        bus_start();
        send_byte(8'hA0, a1);
        send_byte(a, a2);
        send_byte(d, a3);
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(8'hA0, k);
        send_byte(a, k);
        bus_start();
        send_byte(8'hA1, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic t_reset();
        wq(3);
        chk("R1 pull low after reset", sda_pull, 0);
        chk("R1 line idle high", sda_line, 1);
    endtask

    task automatic t_no_start();
        logic k;
        // One-clock SDA dip with SCL high must not count as START (R11).
        sda_m = 1'b0; wq(1); sda_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
        send_byte(8'hA0, k);
        chk("R2 R11 no ack without START", k, 0);
        bus_stop();
    endtask

    task automatic t_address();
        logic k;
        bus_start(); send_byte(8'h90, k); bus_stop();
        chk("R3 wrong id nack", k, 0);
        bus_start(); send_byte(8'hAE, k); bus_stop();
        chk("R3 don't-care bits ack", k, 1);
    endtask

    task automatic t_write_read();
        logic a1, a2, a3;
        logic [7:0] d;
        write_mem(8'h10, 8'h5A, a1, a2, a3);
        chk("R4 write addr ack", a1, 1);
        chk("R4 word addr ack", a2, 1);
        chk("R4 data ack", a3, 1);
        wq(WR + 50);
        read_at(8'h10, d);
        chk("R6 random read data", d, 8'h5A);
    endtask

    task automatic t_busy();
        logic a1, a2, a3, k;
        write_mem(8'h11, 8'hC3, a1, a2, a3);
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk("R9 nack while programming", k, 0);
        wq(WR);
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk("R9 ack after programming", k, 1);
    endtask

    task automatic t_wrap();
        logic a1, a2, a3, k;
        logic [7:0] d0, d1, d2;
        write_mem(8'hFF, 8'h11, a1, a2, a3); wq(WR + 50);
        write_mem(8'h00, 8'h22, a1, a2, a3); wq(WR + 50);
        bus_start();
        send_byte(8'hA0, k); send_byte(8'hFF, k);
        bus_start();
        send_byte(8'hA1, k);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        chk("R5 byte at 255", d0, 8'h11);
        chk("R5 wrap to 0", d1, 8'h22);
        // Current-address read continues at 1 -> location 0x01 unset, use 0x10/0x11 path
        bus_start(); send_byte(8'hA0, k); send_byte(8'h10, k);
        bus_start(); send_byte(8'hA1, k);
        recv_byte(1'b0, d0); bus_stop();
        bus_start(); send_byte(8'hA1, k);
        recv_byte(1'b0, d2); bus_stop();
        chk("R5 pointer advanced", d2, 8'hC3);
    endtask

    task automatic t_lock();
        logic a1, a2, a3;
        logic [7:0] d;
        wr_lock = 1'b1;
        write_mem(8'h10, 8'hEE, a1, a2, a3);
        wr_lock = 1'b0;
        chk("R10 data nack when locked", a3, 0);
        read_at(8'h10, d);
        chk("R10 memory unchanged", d, 8'h5A);
    endtask

    task automatic t_hold_abort();
        logic a1, a2, a3, k;
        logic [7:0] d;
        write_mem(8'h40, 8'h33, a1, a2, a3); wq(WR + 50);
        bus_start();
        send_byte(8'hA0, k); send_byte(8'h40, k);
        bus_start();
        send_byte(8'hA1, k);
        wq(2);
        chk("R7 driving bit7 zero", sda_pull, 1);
        sys_hold = 1'b1; wq(2);
        chk("R7 released in hold", sda_pull, 0);
        sys_hold = 1'b0;
        recv_byte(1'b0, d);
        bus_stop();
        chk("R7 dropped read floats", d, 8'hFF);
        sys_hold = 1'b1;
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk("R7 no ack during hold", k, 0);
        sys_hold = 1'b0;
        bus_start();
        send_byte(8'hA0, a1); send_byte(8'h40, a2);
        sys_hold = 1'b1; wq(50); sys_hold = 1'b0;
        send_byte(8'h99, a3);
        bus_stop();
        chk("R7 data after abort nack", a3, 0);
        read_at(8'h40, d);
        chk("R7 aborted write not stored", d, 8'h33);
    endtask

    task automatic t_hold_during_prog();
        logic a1, a2, a3, k;
        logic [7:0] d;
        write_mem(8'h41, 8'h7E, a1, a2, a3);
        sys_hold = 1'b1; wq(100); sys_hold = 1'b0;
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk("R8 still programming after hold", k, 0);
        wq(WR);
        read_at(8'h41, d);
        chk("R8 byte kept", d, 8'h7E);
    endtask

    initial begin
        rst = 1'b1; sys_hold = 1'b0; wr_lock = 1'b0;
        scl_m = 1'b1; sda_m = 1'b1;
        wq(5);
        rst = 1'b0;
        t_reset();
        t_no_start();
        t_address();
        t_write_read();
        t_busy();
        t_wrap();
        t_lock();
        t_hold_abort();
        t_hold_during_prog();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule